// File: doc/BRIEF.md
# Last-Arriving Operand Tag Predictor

This block serves an out-of-order scheduler whose entries hold a single wakeup comparator instead of two. When an instruction enters the window with both source operands still outstanding, the predictor guesses which source (left or right) will be the last to be broadcast. The scheduler then watches only that tag. Instructions with zero or one outstanding operand do not consult the predictor and come back marked as carrying no prediction.

Predictions come from a table of 2-bit saturating counters. The table index is the XOR-fold of the instruction address with a global history of recent outcomes. A lookup is a valid/ready transaction. The result sits in an output register together with the index that produced it. The scheduler carries this index with the instruction and returns it on the update port with the real outcome. The update port is a plain strobe that is always accepted. It trains the counter at the returned index and shifts the outcome into the history. A separate issue-time check raises a reschedule flag when an issued instruction finds one of its sources not yet produced, meaning the single watched tag was the wrong one.

Back-pressure rules: `lk_ready` is high whenever the output register is empty or is being drained in the same cycle (`pr_ready` high). A lookup is taken on a clock edge where `lk_valid` and `lk_ready` are both high. While `pr_valid` is high and `pr_ready` is low, every result field holds its value.

Top module: `lastop_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly left) and the history is all zeros. `pr_valid` and `resched` are low and `lk_ready` is high.
- R2: The lookup index equals the XOR of all PC bits folded into IDX_W-bit slices (PC bit i lands on index bit i mod IDX_W), XORed with the history register as it stood when the lookup was taken. That index appears on `pr_idx` in the cycle after acceptance.
- R3: For a two-outstanding lookup, `pr_side` is 1 (right) when the indexed counter is 2 or 3, and 0 (left) when it is 0 or 1.
- R4: An update with `upd_last`=1 increments the counter at `upd_idx`, saturating at 3. An update with `upd_last`=0 decrements it, saturating at 0.
- R5: Each update shifts `upd_last` into bit 0 of the history register, and older bits move one place up.
- R6: An update trains the entry named by `upd_idx`, not an index recomputed from the current history.
- R7: A lookup whose `lk_pend` is not 2'b11 (bit 0 = left outstanding, bit 1 = right outstanding) returns `pr_none`=1 and `pr_side`=0.
- R8: `lk_ready` = !`pr_valid` || `pr_ready`. While `pr_valid` is high and `pr_ready` is low, `pr_side`, `pr_none` and `pr_idx` hold, and `pr_valid` stays high.
- R9: `resched` is high in the cycle after `iss_valid` is high with either `iss_left_ok` or `iss_right_ok` low. Otherwise it is low.
- R10: When a lookup and an update hit the same entry in the same cycle, the lookup sees the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_pc | input | PC_W | Instruction address |
| lk_pend | input | 2 | Outstanding sources: bit 0 left, bit 1 right |
| pr_valid | output | 1 | Prediction result valid |
| pr_ready | input | 1 | Consumer takes the result |
| pr_side | output | 1 | Predicted last source: 0 left, 1 right |
| pr_none | output | 1 | No prediction made (bypassed) |
| pr_idx | output | IDX_W | Table index used, to be returned on update |
| upd_valid | input | 1 | Update strobe |
| upd_idx | input | IDX_W | Index captured at lookup |
| upd_last | input | 1 | Actual last source: 0 left, 1 right |
| iss_valid | input | 1 | An instruction is being issued |
| iss_left_ok | input | 1 | Left source value is available |
| iss_right_ok | input | 1 | Right source value is available |
| resched | output | 1 | Reschedule request for the instruction issued last cycle |

## Verification
The bench builds the block with a 16-bit address and a 4-bit index. With these values the table has 16 entries and the history is four bits. Random addresses therefore alias often, and bursts of same-direction updates drive counters into both saturation limits within a few dozen cycles. Four updates flush the history completely, so the history term in the index keeps changing, and returning stale indices on update exercises the captured-index rule. A short table also makes same-cycle lookup and update to one entry frequent enough to occur under random traffic, and consumer stalls exercise the hold rules.

// File: rtl/lop_pkg.sv
package lop_pkg;
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_WEAK_LEFT = 2'd1;
  localparam logic [CNT_W-1:0] CNT_MAX = 2'd3;
  localparam logic [CNT_W-1:0] CNT_MIN = 2'd0;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Upper half of the counter range points right
  function automatic side_e cnt_to_side(input logic [CNT_W-1:0] c);
    return c[CNT_W-1] ? SIDE_RIGHT : SIDE_LEFT;
  endfunction
endpackage

// File: rtl/lop_index_hash.sv
module lop_index_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] folded;

  always_comb begin
    folded = '0;
    for (int i = 0; i < PC_W; i++) begin
      folded[i % IDX_W] = folded[i % IDX_W] ^ pc[i];
    end
  end

  assign idx = folded ^ hist;
endmodule

// File: rtl/lop_history.sv
module lop_history #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else if (shift_en) hist_q <= shift_bit;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
      end
    end
  endgenerate

  assign hist = hist_q;
endmodule

// File: rtl/lop_counter_table.sv
module lop_counter_table
  import lop_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_right
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CNT_W-1:0] cnt_q   [ENTRIES];
  logic [CNT_W-1:0] cnt_nxt [ENTRIES];

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));
      always_comb begin
        cnt_nxt[e] = cnt_q[e];
        if (hit) begin
          if (wr_right) begin
            if (cnt_q[e] != CNT_MAX) cnt_nxt[e] = cnt_q[e] + 1'b1;
          end else begin
            if (cnt_q[e] != CNT_MIN) cnt_nxt[e] = cnt_q[e] - 1'b1;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int k = 0; k < ENTRIES; k++) begin
      if (rst) cnt_q[k] <= CNT_WEAK_LEFT;
      else cnt_q[k] <= cnt_nxt[k];
    end
  end

  // Read returns the stored value, i.e. before any same-cycle write
  assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/lop_resched.sv
module lop_resched (
  input  logic clk,
  input  logic rst,
  input  logic iss_valid,
  input  logic left_ok,
  input  logic right_ok,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else flag_q <= iss_valid && !(left_ok && right_ok);
  end

  assign flag = flag_q;
endmodule

// File: rtl/lastop_predictor.sv
module lastop_predictor
  import lop_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [1:0]       lk_pend,
  output logic             pr_valid,
  input  logic             pr_ready,
  output logic             pr_side,
  output logic             pr_none,
  output logic [IDX_W-1:0] pr_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_last,
  input  logic             iss_valid,
  input  logic             iss_left_ok,
  input  logic             iss_right_ok,
  output logic             resched
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_idx;
  logic [CNT_W-1:0]  lk_cnt;
  logic              take;
  logic              both_out;

  logic             pv_q;
  side_e            side_q;
  logic             none_q;
  logic [IDX_W-1:0] idx_q;

  lop_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .shift_bit(upd_last),
    .hist     (hist_q)
  );

  lop_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash (
    .pc  (lk_pc),
    .hist(hist_q),
    .idx (lk_idx)
  );

  lop_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (lk_idx),
    .rd_cnt  (lk_cnt),
    .wr_en   (upd_valid),
    .wr_idx  (upd_idx),
    .wr_right(upd_last)
  );

  lop_resched u_rs (
    .clk      (clk),
    .rst      (rst),
    .iss_valid(iss_valid),
    .left_ok  (iss_left_ok),
    .right_ok (iss_right_ok),
    .flag     (resched)
  );

  assign lk_ready = !pv_q || pr_ready;
  assign take     = lk_valid && lk_ready;
  assign both_out = &lk_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q   <= 1'b0;
      side_q <= SIDE_LEFT;
      none_q <= 1'b0;
      idx_q  <= '0;
    end else if (take) begin
      pv_q   <= 1'b1;
      side_q <= both_out ? cnt_to_side(lk_cnt) : SIDE_LEFT;
      none_q <= !both_out;
      idx_q  <= lk_idx;
    end else if (pr_ready) begin
      pv_q <= 1'b0;
    end
  end

  assign pr_valid = pv_q;
  assign pr_side  = side_q;
  assign pr_none  = none_q;
  assign pr_idx   = idx_q;
endmodule

// File: rtl/lop_checks.sv
module lop_checks #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_ready,
  input logic             pr_valid,
  input logic             pr_ready,
  input logic             pr_side,
  input logic             pr_none,
  input logic [IDX_W-1:0] pr_idx,
  input logic             upd_valid,
  input logic             upd_last,
  input logic             iss_valid,
  input logic             iss_left_ok,
  input logic             iss_right_ok,
  input logic             resched,
  input logic [IDX_W-1:0] hist
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_ready) |=> (pr_valid && $stable(pr_side) && $stable(pr_none) && $stable(pr_idx)));

  // R8
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_ready |-> (pr_valid && !pr_ready));

  // R7
  bypass_left_chk: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && pr_none) |-> !pr_side);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (hist[0] == $past(upd_last)));

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist));

  // R9
  resched_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !(iss_left_ok && iss_right_ok)) |=> resched);

  // R9
  resched_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && !(iss_left_ok && iss_right_ok)) |=> !resched);
endmodule

bind lastop_predictor lop_checks #(.IDX_W(IDX_W)) u_lop_checks (
  .clk         (clk),
  .rst         (rst),
  .lk_ready    (lk_ready),
  .pr_valid    (pr_valid),
  .pr_ready    (pr_ready),
  .pr_side     (pr_side),
  .pr_none     (pr_none),
  .pr_idx      (pr_idx),
  .upd_valid   (upd_valid),
  .upd_last    (upd_last),
  .iss_valid   (iss_valid),
  .iss_left_ok (iss_left_ok),
  .iss_right_ok(iss_right_ok),
  .resched     (resched),
  .hist        (hist_q)
);

// File: tb/lastop_predictor_bench.sv
module lastop_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 16;
  localparam int IW  = 4;
  localparam int ENT = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, pr_ready = 1'b0, upd_valid = 1'b0, upd_last = 1'b0;
  logic iss_valid = 1'b0, iss_left_ok = 1'b1, iss_right_ok = 1'b1;
  logic [PCW-1:0] lk_pc = '0;
  logic [1:0] lk_pend = 2'b00;
  logic [IW-1:0] upd_idx = '0;
  logic lk_ready, pr_valid, pr_side, pr_none, resched;
  logic [IW-1:0] pr_idx;

  int compared = 0, mismatched = 0;

  lastop_predictor #(.PC_W(PCW), .IDX_W(IW)) u_lastop_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_pend(lk_pend), .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_side(pr_side),
    .pr_none(pr_none), .pr_idx(pr_idx), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_last(upd_last), .iss_valid(iss_valid), .iss_left_ok(iss_left_ok),
    .iss_right_ok(iss_right_ok), .resched(resched)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  int m_cnt [ENT];
  int m_hist;
  bit m_pv, m_side, m_none, m_rs;
  int m_idx;
  int hist_q[$];    // recent indices handed out, reused as stale update indices

  function automatic int ref_fold(logic [PCW-1:0] pc);
    int r = 0;
    for (int i = 0; i < PCW; i++) if (pc[i]) r = r ^ (1 << (i % IW));
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) m_cnt[i] = 1;
    m_hist = 0; m_pv = 0; m_side = 0; m_none = 0; m_rs = 0; m_idx = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      bit rdy;
      rdy = !m_pv || pr_ready;
      // R10: lookup reads the counter before this cycle's update is applied
      if (lk_valid && rdy) begin
        m_idx  = ref_fold(lk_pc) ^ m_hist;
        m_none = (lk_pend != 2'b11);
        m_side = m_none ? 1'b0 : (m_cnt[m_idx] >= 2);
        m_pv   = 1;
      end else if (pr_ready) begin
        m_pv = 0;
      end
      if (upd_valid) begin
        if (upd_last) begin
          if (m_cnt[upd_idx] < 3) m_cnt[upd_idx]++;
        end else begin
          if (m_cnt[upd_idx] > 0) m_cnt[upd_idx]--;
        end
        m_hist = ((m_hist << 1) | int'(upd_last)) & (ENT - 1);
      end
      m_rs = iss_valid && !(iss_left_ok && iss_right_ok);
    end
  end

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R8 lk_ready", int'(lk_ready), int'(!m_pv || pr_ready));
    chk("R8 pr_valid", int'(pr_valid), int'(m_pv));
    chk("R9 resched", int'(resched), int'(m_rs));
    if (m_pv) begin
      chk("R2/R5/R6 pr_idx", int'(pr_idx), m_idx);
      chk("R7 pr_none", int'(pr_none), int'(m_none));
      chk("R3/R4/R6/R10 pr_side", int'(pr_side), int'(m_side));
    end
  endtask

  // mode: 0 mixed, 1 right-heavy, 2 left-heavy, 3 heavy stalls
  task automatic drive(int mode);
    int r;
    lk_valid = ($urandom % 4) != 0;
    lk_pc    = PCW'($urandom);
    lk_pend  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
    pr_ready = (mode == 3) ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
    upd_valid = ($urandom % 2) == 0;
    r = $urandom % 3;
    if (r == 0 && hist_q.size() > 0) upd_idx = IW'(hist_q[$urandom % hist_q.size()]);
    else if (r == 1) upd_idx = IW'(ref_fold(lk_pc) ^ m_hist); // same entry as lookup: R10
    else upd_idx = IW'($urandom);
    if (mode == 1) upd_last = ($urandom % 8) != 0;
    else if (mode == 2) upd_last = ($urandom % 8) == 0;
    else upd_last = $urandom % 2;
    iss_valid    = $urandom % 2;
    iss_left_ok  = ($urandom % 3) != 0;
    iss_right_ok = ($urandom % 3) != 0;
  endtask

  always @(negedge clk) if (!rst && pr_valid) begin
    if (hist_q.size() > 8) void'(hist_q.pop_front());
    hist_q.push_back(int'(pr_idx));
  end

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 pr_valid", int'(pr_valid), 0);
    chk("R1 resched", int'(resched), 0);
    chk("R1 lk_ready", int'(lk_ready), 1);
    rst = 1'b0;
    // R1: first lookup of a fresh table predicts left, history zero
    lk_valid = 1; lk_pc = 16'h1234; lk_pend = 2'b11; pr_ready = 1;
    @(negedge clk);
    chk("R1 first side", int'(pr_side), 0);
    chk("R1 first idx", int'(pr_idx), ref_fold(16'h1234));
    // R7: bypass with one outstanding operand
    lk_pend = 2'b01;
    @(negedge clk);
    chk("R7 bypass none", int'(pr_none), 1);
    chk("R7 bypass side", int'(pr_side), 0);
    compare_all();
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        drive(ph % 4);
        @(negedge clk);
        compare_all();
      end
    end
    done = 1;
  end

  initial begin
    for (int w = 0; w < 100000 && !done; w++) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule